// File: doc/BRIEF.md
# Tuner Synthesizer Register Loader

This block sits behind an already framed serial write port. It receives start and stop flags and a strobe that marks the last bit of each byte, which also presents the byte. From these it programs three configuration registers of a frequency synthesizer: a 15-bit divider, an 8-bit control word and a 4-bit band switch word. The first byte of a transfer is a module address. Two of its bits are strapped by the `ma_sel_i` input, so several loaders can share one bus. The block raises an acknowledge request for a matching write address and for every data byte it accepts.

After the address, the top bit of the first data byte picks the branch. If it is clear, two divider bytes follow. If it is set, a control byte and then a band byte follow. An internal pointer moves on by one with each byte and wraps from one branch into the other, so one transfer can program everything. A transfer may also stop part way through. The divider is loaded as a pair: the first divider byte is kept in a shadow register, and the divider changes only when the second divider byte ends.

Top module: `tuner_reg_loader`

## Requirements
- R1: After reset, `div_o`, `ctrl_o`, `band_o` and `ack_o` are all zero.
- R2: The address byte is accepted only if it equals binary 11000, then `ma_sel_i[1]`, then `ma_sel_i[0]`, then a write bit of 0 in bit 0. Any other address byte, including one with bit 0 set, is not acknowledged. All bytes after it are then ignored (no acknowledge, no register change) until the next start.
- R3: `ack_o` is high for exactly the one cycle that follows the byte strobe of an accepted address byte or an accepted data byte. At all other times it is low.
- R4: If bit 7 of the first data byte is 0, that byte is the first divider byte and by itself changes nothing visible. When the next byte ends, `div_o` becomes {first[6:0], second[7:0]}.
- R5: If bit 7 of the first data byte is 1, that byte is loaded whole into `ctrl_o`. The byte after it loads its bits [3:0] into `band_o`, and `div_o` is left unchanged.
- R6: The pointer keeps cycling in the order divider-first, divider-second, control, band, divider-first, and so on. After the first data byte, a byte's role comes from its position alone and not from its bit 7.
- R7: A stop ends the transfer, so bytes that follow it are ignored. A start at any point aborts the current sequence and expects an address byte next. A divider-first byte that was not followed by its pair never reaches `div_o`.
- R8: A register loaded by a byte shows its new value in the cycle after that byte's strobe. It holds its old value during the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| byte_end_i | input | 1 | Last bit of a byte received; `byte_i` is valid |
| byte_i | input | 8 | Received byte |
| ma_sel_i | input | 2 | Strapped programmable address bits |
| ack_o | output | 1 | Acknowledge request for the byte just ended |
| div_o | output | 15 | Divider register |
| ctrl_o | output | 8 | Control register |
| band_o | output | 4 | Band switch outputs |

## Verification
Each of the block's results appears one clock after the byte strobe that causes it. This holds for the acknowledge request and for any register update, because one register stage lies between the strobe and each output. The bench raises a strobe at a falling edge and lowers it at the next falling edge, and it samples the outputs at that same falling edge. That point falls after the single rising edge that captured the byte. A dedicated test also samples during the strobe cycle, to confirm that the old value is still present there.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [2:0] {
    PTR_IDLE  = 3'd0,
    PTR_ADDR  = 3'd1,
    PTR_FIRST = 3'd2,
    PTR_DIVHI = 3'd3,
    PTR_DIVLO = 3'd4,
    PTR_CTRL  = 3'd5,
    PTR_BAND  = 3'd6
  } ptr_e;

  typedef struct packed {
    logic shadow;
    logic div;
    logic ctrl;
    logic band;
  } load_t;
endpackage

// File: rtl/tsl_addr_match.sv
module tsl_addr_match #(
  parameter int          BYTE_W  = 8,
  parameter int          SEL_W   = 2,
  parameter logic [4:0]  FIXED   = 5'b11000
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SEL_W-1:0]  ma_sel_i,
  output logic              hit_o
);
  localparam int FIX_W = BYTE_W - SEL_W - 1;
  logic [BYTE_W-1:0] expect_w;

  always_comb begin
    expect_w = {FIXED[FIX_W-1:0], ma_sel_i, 1'b0};
    hit_o    = (byte_i == expect_w);
  end
endmodule

// File: rtl/tsl_seq.sv
module tsl_seq
  import tsl_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_end_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              hit_i,
  output load_t             load_o,
  output logic              ack_o
);
  ptr_e ptr_q, ptr_d;
  logic ack_q, ack_d;

  always_comb begin
    ptr_d  = ptr_q;
    ack_d  = 1'b0;
    load_o = '0;
    if (start_i) begin
      ptr_d = PTR_ADDR;
    end else if (stop_i) begin
      ptr_d = PTR_IDLE;
    end else if (byte_end_i) begin
      unique case (ptr_q)
        PTR_IDLE: ptr_d = PTR_IDLE;
        PTR_ADDR: begin
          ack_d = hit_i;
          ptr_d = hit_i ? PTR_FIRST : PTR_IDLE;
        end
        PTR_FIRST: begin
          ack_d = 1'b1;
          if (byte_i[BYTE_W-1]) begin
            load_o.ctrl = 1'b1;
            ptr_d       = PTR_BAND;
          end else begin
            load_o.shadow = 1'b1;
            ptr_d         = PTR_DIVLO;
          end
        end
        PTR_DIVHI: begin
          ack_d         = 1'b1;
          load_o.shadow = 1'b1;
          ptr_d         = PTR_DIVLO;
        end
        PTR_DIVLO: begin
          ack_d      = 1'b1;
          load_o.div = 1'b1;
          ptr_d      = PTR_CTRL;
        end
        PTR_CTRL: begin
          ack_d       = 1'b1;
          load_o.ctrl = 1'b1;
          ptr_d       = PTR_BAND;
        end
        PTR_BAND: begin
          ack_d       = 1'b1;
          load_o.band = 1'b1;
          ptr_d       = PTR_DIVHI;
        end
        default: ptr_d = PTR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_IDLE;
      ack_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      ack_q <= ack_d;
    end
  end

  assign ack_o = ack_q;

  // R3
  ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> $past(byte_end_i));
  // R7
  start_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ptr_q == PTR_ADDR));
  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == PTR_IDLE && !start_i) |=> !ack_q);
  // R6
  band_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == PTR_BAND && byte_end_i && !start_i && !stop_i) |=> (ptr_q == PTR_DIVHI));
endmodule

// File: rtl/tsl_regs.sv
module tsl_regs
  import tsl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 15,
  parameter int BAND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  load_t             load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BAND_W-1:0] band_o
);
  localparam int SHD_W = DIV_W - BYTE_W;

  logic [SHD_W-1:0]  shd_q, shd_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BAND_W-1:0] band_q, band_d;

  always_comb begin
    shd_d  = load_i.shadow ? byte_i[SHD_W-1:0] : shd_q;
    div_d  = load_i.div    ? {shd_q, byte_i}   : div_q;
    ctrl_d = load_i.ctrl   ? byte_i            : ctrl_q;
    band_d = load_i.band   ? byte_i[BAND_W-1:0] : band_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      div_q  <= '0;
      ctrl_q <= '0;
      band_q <= '0;
    end else begin
      shd_q  <= shd_d;
      div_q  <= div_d;
      ctrl_q <= ctrl_d;
      band_q <= band_d;
    end
  end

  assign div_o  = div_q;
  assign ctrl_o = ctrl_q;
  assign band_o = band_q;

  // R4
  shadow_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i.shadow && !load_i.div) |=> $stable(div_q));
endmodule

// File: rtl/tuner_reg_loader.sv
module tuner_reg_loader
  import tsl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 2,
  parameter int DIV_W  = 15,
  parameter int BAND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_end_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [SEL_W-1:0]  ma_sel_i,
  output logic              ack_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BAND_W-1:0] band_o
);
  logic  hit_w;
  load_t load_w;

  tsl_addr_match #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_match (
    .byte_i   (byte_i),
    .ma_sel_i (ma_sel_i),
    .hit_o    (hit_w)
  );

  tsl_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_end_i (byte_end_i),
    .byte_i     (byte_i),
    .hit_i      (hit_w),
    .load_o     (load_w),
    .ack_o      (ack_o)
  );

  tsl_regs #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .BAND_W(BAND_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .byte_i (byte_i),
    .div_o  (div_o),
    .ctrl_o (ctrl_o),
    .band_o (band_o)
  );

  // R8
  div_moves_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_o) |-> $past(byte_end_i && !start_i && !stop_i));
  // R5
  band_moves_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_o) |-> ack_o);
  // R5
  ctrl_moves_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> ack_o);
endmodule

// File: tb/tuner_reg_loader_tb_top.sv
module tuner_reg_loader_tb_top;
  logic        clk, rst_n, start_i, stop_i, byte_end_i, ack_o;
  logic [7:0]  byte_i, ctrl_o;
  logic [1:0]  ma_sel_i;
  logic [14:0] div_o;
  logic [3:0]  band_o;

  int n_chk, n_bad;
  bit done;
  int exp_div, exp_ctrl, exp_band;

  tuner_reg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_end_i(byte_end_i), .byte_i(byte_i), .ma_sel_i(ma_sel_i),
    .ack_o(ack_o), .div_o(div_o), .ctrl_o(ctrl_o), .band_o(band_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regs_chk(input string req);
    chk(req, int'(div_o), exp_div);
    chk(req, int'(ctrl_o), exp_ctrl);
    chk(req, int'(band_o), exp_band);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    @(negedge clk); byte_end_i = 1'b1; byte_i = b;
    @(negedge clk); byte_end_i = 1'b0; a = ack_o;
  endtask

  task automatic addr(input logic [1:0] ms);
    logic a;
    send({5'b11000, ms, 1'b0}, a);
    chk("R2", int'(a), 1);
  endtask

  initial begin
    logic a;
    n_chk = 0; n_bad = 0; done = 0;
    start_i = 0; stop_i = 0; byte_end_i = 0; byte_i = 0; ma_sel_i = 2'd1;
    rst_n = 0;
    exp_div = 0; exp_ctrl = 0; exp_band = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(ack_o), 0);
    regs_chk("R1");

    // R2 address sweep over strap values, address bits and write bit
    for (int ms = 0; ms < 4; ms++) begin
      ma_sel_i = 2'(ms);
      for (int ab = 0; ab < 4; ab++) begin
        for (int rw = 0; rw < 2; rw++) begin
          logic [7:0] cb;
          bit m;
          m = (ab == ms) && (rw == 0);
          pulse_start();
          send({5'b11000, 2'(ab), 1'(rw)}, a);
          chk("R2 addr ack", int'(a), int'(m));
          cb = 8'h80 | 8'(ms * 16 + ab * 2 + rw);
          send(cb, a);
          chk("R2 data ack", int'(a), int'(m));
          if (m) exp_ctrl = int'(cb);
          regs_chk("R2");
          pulse_stop();
        end
      end
    end
    // R2 wrong fixed field
    ma_sel_i = 2'd2;
    pulse_start();
    send(8'hC4 ^ 8'h20, a);
    chk("R2 fixed", int'(a), 0);
    send(8'h81, a);
    chk("R2 ignore", int'(a), 0);
    regs_chk("R2");
    pulse_stop();

    // R4 R6 divider first, full wrap
    for (int k = 0; k < 64; k++) begin
      int d, d2;
      d  = (k * 517 + 3) & 32'h7fff;
      d2 = (d ^ 32'h5a5a) & 32'h7fff;
      pulse_start();
      addr(2'd2);
      send({1'b0, 7'(d >> 8)}, a);
      chk("R3", int'(a), 1);
      regs_chk("R4 shadow");
      send(8'(d), a);
      exp_div = d;
      regs_chk("R4 pair");
      send(8'h80 | 8'(k), a);
      exp_ctrl = 32'h80 | k;
      regs_chk("R6 ctrl");
      send(8'(k * 3), a);
      exp_band = (k * 3) & 15;
      regs_chk("R6 band");
      send({1'b1, 7'(d2 >> 8)}, a);
      chk("R6 ack", int'(a), 1);
      regs_chk("R6 msb ignored");
      send(8'(d2), a);
      exp_div = d2;
      regs_chk("R6 div again");
      pulse_stop();
    end

    // R5 control first then band then divider
    pulse_start();
    addr(2'd2);
    send(8'hA7, a);
    exp_ctrl = 32'hA7;
    regs_chk("R5 ctrl");
    send(8'h3C, a);
    exp_band = 32'hC;
    regs_chk("R5 band");
    send(8'h12, a);
    send(8'h34, a);
    exp_div = 32'h1234;
    regs_chk("R6 after band");
    pulse_stop();

    // R7 bytes after stop ignored
    send(8'h9F, a);
    chk("R7 after stop", int'(a), 0);
    regs_chk("R7");

    // R7 start mid-pair discards shadow
    pulse_start();
    addr(2'd2);
    send(8'h7F, a);
    pulse_start();
    addr(2'd2);
    send(8'hC3, a);
    exp_ctrl = 32'hC3;
    regs_chk("R7 restart");
    send(8'h05, a);
    exp_band = 5;
    send(8'h00, a);
    send(8'h01, a);
    exp_div = 1;
    regs_chk("R7 shadow from new pair");
    pulse_stop();

    // R8 old value during strobe, new value one cycle later
    pulse_start();
    addr(2'd2);
    @(negedge clk); byte_end_i = 1'b1; byte_i = 8'hE1;
    #2;
    chk("R8 during strobe", int'(ctrl_o), exp_ctrl);
    chk("R3 during strobe", int'(ack_o), 0);
    @(negedge clk); byte_end_i = 1'b0;
    chk("R8 next cycle", int'(ctrl_o), 32'hE1);
    chk("R3 one cycle", int'(ack_o), 1);
    @(negedge clk);
    chk("R3 drops", int'(ack_o), 0);
    pulse_stop();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule